// File: doc/BRIEF.md
# SCL Half-Period Timer with Clock Stretching

This block is the countdown timer that paces each SCL half-period of an I2C master. A 7-bit reload value sets the period length. The counter loses one count on every clock where one of the phase ticks is asserted. Two such ticks occur in each instruction cycle, so the count falls by two per instruction cycle. When the count runs out, the block emits a one-clock timeout and parks at zero, waiting for the next reload.

Slaves may stretch the clock. When the master lets go of SCL, the timer does not reload at once. It waits until the bus line is actually sampled high, so a slave that holds SCL low lengthens the half-period instead of shortening it. A run control starts the timer: its rising edge reloads the counter. Dropping the run control freezes the counter where it stands. The bit-level sequencing that drives the release control and consumes the timeout sits outside this block.

Top module: `scl_baud_timer`

## Requirements
- R1: While reset is asserted and after it is released, count_o is 0 and timeout_o is 0. Until run_i is first raised, ticks change nothing.
- R2: On the clock where run_i rises from 0 to 1, count_o takes reload_val_i.
- R3: While counting, each clock with a phase tick asserted lowers count_o by exactly one. tick_i[0] is phase A and tick_i[1] is phase B, and at most one is set per clock. A clock without a tick leaves count_o unchanged.
- R4: A tick taken while count_o is 1 or 0 drives count_o to 0 and sets timeout_o for exactly one clock. After that the count stays at 0 and later ticks are ignored until the next reload.
- R5: On a rising edge of scl_rel_i with scl_in_i low, the timer enters a wait state. While waiting with scl_in_i low, count_o neither reloads nor decrements, even when ticks arrive.
- R6: On the clock where scl_in_i is high after a release, either while waiting or on the release edge itself, count_o takes reload_val_i and counting resumes.
- R7: A reload (R2 or R6) on a clock that also carries a tick loads reload_val_i with no decrement applied.
- R8: A reload value of 0 gives timeout_o on the first tick after the reload.
- R9: While run_i is 0, count_o is frozen and timeout_o stays 0. Edges on scl_rel_i and scl_in_i during this time cause no reload.
- R10: The full reload value of 127 counts down through every value and times out on the 127th tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reload_val_i | input | 7 | Half-period reload value |
| tick_i | input | 2 | Phase tick enables, one-hot or zero |
| run_i | input | 1 | 1 = run, 0 = suspend; rising edge reloads |
| scl_rel_i | input | 1 | Master has released SCL |
| scl_in_i | input | 1 | Sampled SCL line level |
| timeout_o | output | 1 | One-clock pulse when the count expires |
| count_o | output | 7 | Current count |

## Verification
Some rules are checked on every cycle:
- a single-step decrement;
- a reload landing the sampled reload value;
- a timeout lasting only one clock and only at zero;
- a frozen count while suspended or while a slave holds SCL low;
- one-hot phase ticks.

Other behaviour can only be shown by the bench's scenarios. These are the ordering of reload over decrement, the reload timing at the release edge compared with a later SCL rise, the immediate timeout on a zero reload, the full 127-tick span, and the fact that release edges during suspension are ignored.

// File: rtl/scl_bg_pkg.sv
package scl_bg_pkg;
  typedef enum logic [1:0] {
    ST_SUSP  = 2'd0,
    ST_COUNT = 2'd1,
    ST_WAIT  = 2'd2,
    ST_HOLD  = 2'd3
  } bg_state_e;
endpackage

// File: rtl/scl_bg_tick_merge.sv
module scl_bg_tick_merge #(
  parameter int NUM_PHASES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_PHASES-1:0] tick_i,
  output logic                  tick_o
);
  logic [NUM_PHASES:0] acc;
  assign acc[0] = 1'b0;
  for (genvar g = 0; g < NUM_PHASES; g++) begin : g_or
    assign acc[g+1] = acc[g] | tick_i[g];
  end
  assign tick_o = acc[NUM_PHASES];

  // phases never coincide
  p_phase_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(tick_i));
endmodule

// File: rtl/scl_bg_arbiter.sv
module scl_bg_arbiter
  import scl_bg_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      run_i,
  input  logic      scl_rel_i,
  input  logic      scl_in_i,
  input  logic      tick_i,
  input  logic      near_zero_i,
  output logic      load_o,
  output logic      dec_o,
  output bg_state_e state_o
);
  bg_state_e st_q, st_d;
  logic run_q, rel_q;
  logic run_rise, rel_rise, armed;

  assign run_rise = run_i & ~run_q;
  assign rel_rise = scl_rel_i & ~rel_q;
  assign armed    = (st_q == ST_WAIT) | rel_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_SUSP;
      run_q <= 1'b0;
      rel_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      run_q <= run_i;
      rel_q <= scl_rel_i;
    end
  end

  always_comb begin
    st_d   = st_q;
    load_o = 1'b0;
    dec_o  = 1'b0;
    if (!run_i) begin
      st_d = ST_SUSP;
    end else if (run_rise) begin
      load_o = 1'b1;
      st_d   = ST_COUNT;
    end else if (armed && scl_in_i) begin
      // line seen high after release: reload wins over any tick
      load_o = 1'b1;
      st_d   = ST_COUNT;
    end else if (rel_rise) begin
      st_d = ST_WAIT;
    end else if (st_q == ST_COUNT && tick_i) begin
      dec_o = 1'b1;
      if (near_zero_i) st_d = ST_HOLD;
    end
  end

  assign state_o = st_q;

  p_hold_no_dec_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HOLD) |-> !dec_o);
  p_load_dec_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_o && dec_o));
endmodule

// File: rtl/scl_bg_counter.sv
module scl_bg_counter #(
  parameter int CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             dec_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             near_zero_o,
  output logic [CNT_W-1:0] count_o,
  output logic             timeout_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             to_q;

  assign near_zero_o = (cnt_q <= ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      to_q  <= 1'b0;
    end else if (load_i) begin
      cnt_q <= reload_i;
      to_q  <= 1'b0;
    end else if (dec_i) begin
      if (near_zero_o) begin
        cnt_q <= '0;
        to_q  <= 1'b1;
      end else begin
        cnt_q <= cnt_q - ONE;
        to_q  <= 1'b0;
      end
    end else begin
      to_q <= 1'b0;
    end
  end

  assign count_o   = cnt_q;
  assign timeout_o = to_q;

  p_dec_by_one_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !load_i && cnt_q > ONE) |=> cnt_q == $past(cnt_q) - ONE);
  p_to_at_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    to_q |-> cnt_q == '0);
  p_to_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    to_q |=> !to_q);
  p_load_value_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(reload_i));
endmodule

// File: rtl/scl_baud_timer.sv
module scl_baud_timer
  import scl_bg_pkg::*;
#(
  parameter int CNT_W      = 7,
  parameter int NUM_PHASES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [CNT_W-1:0]      reload_val_i,
  input  logic [NUM_PHASES-1:0] tick_i,
  input  logic                  run_i,
  input  logic                  scl_rel_i,
  input  logic                  scl_in_i,
  output logic                  timeout_o,
  output logic [CNT_W-1:0]      count_o
);
  logic      tick_any, near_zero, load, dec;
  bg_state_e state;

  scl_bg_tick_merge #(.NUM_PHASES(NUM_PHASES)) u_merge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .tick_o (tick_any)
  );

  scl_bg_arbiter u_arb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run_i),
    .scl_rel_i   (scl_rel_i),
    .scl_in_i    (scl_in_i),
    .tick_i      (tick_any),
    .near_zero_i (near_zero),
    .load_o      (load),
    .dec_o       (dec),
    .state_o     (state)
  );

  scl_bg_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .dec_i       (dec),
    .reload_i    (reload_val_i),
    .near_zero_o (near_zero),
    .count_o     (count_o),
    .timeout_o   (timeout_o)
  );

  // slave stretching: count held while line stays low
  p_stretch_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_WAIT && run_i && !scl_in_i) |=> $stable(count_o));
  p_suspend_freeze_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> ($stable(count_o) && !timeout_o));
endmodule

// File: tb/scl_baud_timer_tb.sv
module scl_baud_timer_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [6:0] reload_val_i = '0;
  logic [1:0] tick_i = '0;
  logic       run_i = 1'b0;
  logic       scl_rel_i = 1'b0;
  logic       scl_in_i = 1'b0;
  logic       timeout_o;
  logic [6:0] count_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2 clk_i = ~clk_i;

  scl_baud_timer dut_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .reload_val_i (reload_val_i),
    .tick_i       (tick_i),
    .run_i        (run_i),
    .scl_rel_i    (scl_rel_i),
    .scl_in_i     (scl_in_i),
    .timeout_o    (timeout_o),
    .count_o      (count_o)
  );

  // fields: req[23:20] run[19] rel[18] scl[17] tick[16:15] reload[14:8] cnt[7:1] to[0]
  localparam int NV = 34;
  localparam logic [23:0] VECS [NV] = '{
    {4'd2, 1'b1,1'b0,1'b0, 2'b00, 7'd3, 7'd3, 1'b0},  // R2 start
    {4'd3, 1'b1,1'b0,1'b0, 2'b01, 7'd3, 7'd2, 1'b0},  // R3 phase A
    {4'd3, 1'b1,1'b0,1'b0, 2'b00, 7'd3, 7'd2, 1'b0},  // R3 no tick
    {4'd3, 1'b1,1'b0,1'b0, 2'b10, 7'd3, 7'd1, 1'b0},  // R3 phase B
    {4'd4, 1'b1,1'b0,1'b0, 2'b01, 7'd3, 7'd0, 1'b1},  // R4 timeout
    {4'd4, 1'b1,1'b0,1'b0, 2'b10, 7'd3, 7'd0, 1'b0},  // R4 hold-off
    {4'd5, 1'b1,1'b1,1'b0, 2'b00, 7'd3, 7'd0, 1'b0},  // R5 release, line low
    {4'd5, 1'b1,1'b1,1'b0, 2'b01, 7'd3, 7'd0, 1'b0},
    {4'd5, 1'b1,1'b1,1'b0, 2'b10, 7'd3, 7'd0, 1'b0},
    {4'd6, 1'b1,1'b1,1'b1, 2'b00, 7'd3, 7'd3, 1'b0},  // R6 line high
    {4'd3, 1'b1,1'b1,1'b1, 2'b01, 7'd3, 7'd2, 1'b0},
    {4'd3, 1'b1,1'b0,1'b0, 2'b10, 7'd3, 7'd1, 1'b0},
    {4'd4, 1'b1,1'b0,1'b0, 2'b01, 7'd3, 7'd0, 1'b1},
    {4'd7, 1'b1,1'b1,1'b1, 2'b10, 7'd3, 7'd3, 1'b0},  // R7 reload beats tick
    {4'd3, 1'b1,1'b1,1'b1, 2'b01, 7'd3, 7'd2, 1'b0},
    {4'd3, 1'b1,1'b0,1'b0, 2'b10, 7'd0, 7'd1, 1'b0},
    {4'd4, 1'b1,1'b0,1'b0, 2'b01, 7'd0, 7'd0, 1'b1},
    {4'd8, 1'b1,1'b1,1'b1, 2'b00, 7'd0, 7'd0, 1'b0},  // R8 zero reload
    {4'd8, 1'b1,1'b1,1'b1, 2'b01, 7'd0, 7'd0, 1'b1},
    {4'd4, 1'b1,1'b0,1'b0, 2'b00, 7'd0, 7'd0, 1'b0},
    {4'd6, 1'b1,1'b1,1'b1, 2'b00, 7'd5, 7'd5, 1'b0},
    {4'd3, 1'b1,1'b1,1'b1, 2'b01, 7'd5, 7'd4, 1'b0},
    {4'd9, 1'b0,1'b1,1'b1, 2'b10, 7'd5, 7'd4, 1'b0},  // R9 suspend
    {4'd9, 1'b0,1'b1,1'b1, 2'b01, 7'd5, 7'd4, 1'b0},
    {4'd9, 1'b0,1'b0,1'b0, 2'b00, 7'd5, 7'd4, 1'b0},
    {4'd9, 1'b0,1'b1,1'b1, 2'b01, 7'd5, 7'd4, 1'b0},  // release ignored
    {4'd2, 1'b1,1'b1,1'b1, 2'b01, 7'd5, 7'd5, 1'b0},  // R2 restart over tick
    {4'd3, 1'b1,1'b1,1'b1, 2'b10, 7'd5, 7'd4, 1'b0},
    {4'd3, 1'b1,1'b1,1'b1, 2'b01, 7'd5, 7'd3, 1'b0},
    {4'd3, 1'b1,1'b1,1'b1, 2'b10, 7'd5, 7'd2, 1'b0},
    {4'd3, 1'b1,1'b1,1'b1, 2'b01, 7'd5, 7'd1, 1'b0},
    {4'd9, 1'b0,1'b1,1'b1, 2'b10, 7'd5, 7'd1, 1'b0},  // no timeout when frozen
    {4'd9, 1'b0,1'b1,1'b1, 2'b01, 7'd5, 7'd1, 1'b0},
    {4'd2, 1'b1,1'b1,1'b1, 2'b00, 7'd5, 7'd5, 1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic run, input logic rel, input logic scl,
                      input logic [1:0] tk, input logic [6:0] rv);
    @(negedge clk_i);
    run_i = run; scl_rel_i = rel; scl_in_i = scl; tick_i = tk; reload_val_i = rv;
    @(posedge clk_i);
    #1;
  endtask

  initial begin
    // R1 reset state
    repeat (3) @(posedge clk_i);
    #1;
    chk("R1 count in reset", int'(count_o), 0);
    chk("R1 timeout in reset", int'(timeout_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    step(1'b0, 1'b0, 1'b0, 2'b01, 7'd9);
    chk("R1 idle after reset", int'(count_o), 0);
    chk("R1 idle timeout", int'(timeout_o), 0);
    step(1'b0, 1'b0, 1'b0, 2'b00, 7'd3);

    for (int i = 0; i < NV; i++) begin
      logic [23:0] v;
      string tag;
      v = VECS[i];
      step(v[19], v[18], v[17], v[16:15], v[14:8]);
      tag = $sformatf("R%0d row %0d", int'(v[23:20]), i);
      chk({tag, " count"}, int'(count_o), int'(v[7:1]));
      chk({tag, " timeout"}, int'(timeout_o), int'(v[0]));
    end

    // R10 full range
    step(1'b0, 1'b1, 1'b1, 2'b00, 7'd127);
    step(1'b1, 1'b1, 1'b1, 2'b00, 7'd127);
    chk("R10 load 127", int'(count_o), 127);
    for (int i = 1; i < 127; i++) begin
      step(1'b1, 1'b1, 1'b1, (i % 2) ? 2'b01 : 2'b10, 7'd127);
      chk("R10 count", int'(count_o), 127 - i);
      chk("R10 no early timeout", int'(timeout_o), 0);
    end
    step(1'b1, 1'b1, 1'b1, 2'b10, 7'd127);
    chk("R10 final count", int'(count_o), 0);
    chk("R10 timeout on tick 127", int'(timeout_o), 1);

    // R5 long stretch, then R6 reload when line rises
    step(1'b1, 1'b0, 1'b0, 2'b00, 7'd40);
    for (int i = 0; i < 20; i++) begin
      step(1'b1, 1'b1, 1'b0, (i % 2) ? 2'b10 : 2'b01, 7'd40);
      chk("R5 stretched hold", int'(count_o), 0);
      chk("R5 no timeout while held", int'(timeout_o), 0);
    end
    step(1'b1, 1'b1, 1'b1, 2'b01, 7'd40);
    chk("R6 reload after stretch", int'(count_o), 40);
    step(1'b1, 1'b1, 1'b1, 2'b10, 7'd40);
    chk("R3 count after stretch", int'(count_o), 39);

    // R1 asynchronous reset mid-count
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("R1 async reset count", int'(count_o), 0);
    chk("R1 async reset timeout", int'(timeout_o), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule